// File: doc/BRIEF.md
# Serial Control and Status Shifter

This block is the serial slave front end of a multi-output load driver. A host frames each transfer with an active-low select. During the frame the block takes in a 16-bit control word and sends out a 16-bit status word at the same time. Both words move least significant bit first. The control word reaches the holding register, and so the driver logic around the block, only when the frame closes with a whole number of 16-bit words.

The select, serial clock and serial data inputs are first synchronized into a system clock that runs at least eight times faster than the serial clock. All edges are detected in that domain. The status word is captured the moment select falls. Status bit 0 is the temperature warning, and it appears on the data output before any clock is given, so the host can poll it with a bare select pulse.

Once the status bits have gone out, the bits received on the data input follow them on the data output. Several devices can therefore be chained, and each one keeps the last 16 bits it received. The held control word uses this layout, which the neighbouring logic decodes:

| Bit | Meaning |
|---|---|
| 0 | Status clear request |
| 1 to 12 | Switch enables, low-side then high-side, for outputs 1 to 6 |
| 13 | Open-load test enable, active low |
| 14 | Timer range |
| 15 | Run (low means standby) |

Top module: `serial_ctrl_shifter`

## Requirements
- R1: While reset is held, ctrl_o is 16'h2000 (only bit 13 set), commit_o is 0 and sdo_en_o is 0.
- R2: sdo_en_o is 1 while the synchronized cs_ni is low and 0 while it is high.
- R3: On the falling edge of cs_ni the block captures status_i, and status bit 0 appears on sdo_o before any serial clock edge.
- R4: sdi_i is sampled on each falling edge of sck_i within a frame, least significant bit first. The committed word holds the k-th of its last 16 sampled bits at bit k.
- R5: sdo_o advances one position on each rising edge of sck_i that follows a falling edge in the frame. After the k-th such rising edge (k < 16), sdo_o shows status bit k.
- R6: After the 16th rising edge and every later one, sdo_o shows the sdi_i bits in the order they were sampled, starting with the first bit of the frame.
- R7: When cs_ni rises after a nonzero multiple of 16 falling clock edges, ctrl_o takes the last 16 sampled bits and commit_o is high for exactly one system clock.
- R8: When cs_ni rises after any other number of falling clock edges, including zero, ctrl_o is unchanged and commit_o stays 0.
- R9: Edges on sck_i while cs_ni is high change neither ctrl_o nor commit_o.
- R10: A change of status_i after the select has fallen does not change the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, sampled on falling sck_i |
| status_i | input | 16 | Parallel status word, captured at select fall |
| sdo_o | output | 1 | Serial data out, changes on rising sck_i |
| sdo_en_o | output | 1 | Drive enable for the tristate data output pad |
| ctrl_o | output | 16 | Held control word |
| commit_o | output | 1 | One-cycle strobe when ctrl_o is loaded |

## Verification
Two functions share a frame when it lasts 32 clocks. Status words have to make way for forwarded input bits on the data output, and the same frame must still commit its last 16 received bits when select rises. The bench runs such a chained frame and checks the output bit after every rising clock against a stream it builds itself: the status word followed by the bits sent. It then checks that the held word equals the second half of what was sent, and that exactly one strobe was counted. Frames of 10 and 17 clocks are sent to show that a frame which is not a multiple of 16 commits nothing, even after a full word has passed.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned OL_N_BIT = 13;  // open-load test enable, active low
  localparam logic [WORD_W-1:0] CTRL_RST = WORD_W'(1) << OL_N_BIT;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[i] <= RST_VAL;
      end else begin
        if (i == 0) stg_q[i] <= d_i;
        else        stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              sck_fall_i,
  input  logic              sck_rise_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] status_i,
  output logic [WORD_W-1:0] rx_o,
  output logic              tx_bit_o,
  output logic              full_o
);
  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q, last_di_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      last_di_q <= 1'b0;
    end else if (frame_start_i) begin
      tx_q   <= status_i;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (sck_fall_i) begin
        rx_q      <= {sdi_i, rx_q[WORD_W-1:1]};
        cnt_q     <= (cnt_q == CNT_W'(WORD_W)) ? CNT_W'(1) : cnt_q + CNT_W'(1);
        pend_q    <= 1'b1;
        last_di_q <= sdi_i;
      end
      // advance only once per sampled bit; forwarded data enters at the top
      if (sck_rise_i && pend_q) begin
        tx_q   <= {last_di_q, tx_q[WORD_W-1:1]};
        pend_q <= 1'b0;
      end
    end
  end

  assign rx_o     = rx_q;
  assign tx_bit_o = tx_q[0];
  assign full_o   = (cnt_q == CNT_W'(WORD_W));

  p_status_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> tx_q == $past(status_i));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));

  p_hold_without_clock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !sck_rise_i) |=> $stable(tx_q));
endmodule

// File: rtl/ssc_commit.sv
module ssc_commit #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] rx_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] ctrl_q;
  logic              commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= RST_VAL;
      commit_q <= 1'b0;
    end else begin
      commit_q <= frame_end_i && full_i;
      if (frame_end_i && full_i) ctrl_q <= rx_i;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign commit_o = commit_q;

  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> !commit_q);

  p_early_end_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !full_i) |=> ($stable(ctrl_q) && !commit_q));

  p_ctrl_only_on_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> commit_q);
endmodule

// File: rtl/serial_ctrl_shifter.sv
module serial_ctrl_shifter
  import ssc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              commit_o
);
  logic cs_s, sck_s, sdi_s;
  logic cs_d, sck_d;
  logic cs_fall, cs_rise, sck_fall, sck_rise;
  logic [WORD_W-1:0] rx_w;
  logic full_w, tx_bit_w;

  ssc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   ({cs_s, sck_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b1;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  =  cs_d & ~cs_s;
  assign cs_rise  = ~cs_d &  cs_s;
  assign sck_fall =  sck_d & ~sck_s & ~cs_s;
  assign sck_rise = ~sck_d &  sck_s & ~cs_s;

  ssc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(cs_fall),
    .sck_fall_i   (sck_fall),
    .sck_rise_i   (sck_rise),
    .sdi_i        (sdi_s),
    .status_i     (status_i),
    .rx_o         (rx_w),
    .tx_bit_o     (tx_bit_w),
    .full_o       (full_w)
  );

  ssc_commit #(.WORD_W(WORD_W), .RST_VAL(CTRL_RST)) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_end_i(cs_rise),
    .full_i     (full_w),
    .rx_i       (rx_w),
    .ctrl_o     (ctrl_o),
    .commit_o   (commit_o)
  );

  // enable and loaded status leave the same register stage
  assign sdo_en_o = ~cs_d;
  assign sdo_o    = tx_bit_w;

  p_idle_clk_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && cs_d) |=> $stable(full_w));

  p_no_commit_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_d && !cs_s) |=> !commit_o);
endmodule

// File: tb/tb_serial_ctrl_shifter.sv
module tb_serial_ctrl_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic [15:0] status = '0;
  logic sdo, sdo_en, commit;
  logic [15:0] ctrl;

  int n_cmp = 0, n_bad = 0;
  int commits_seen = 0, commits_exp = 0;
  logic [15:0] ctrl_exp = 16'h2000;
  logic [15:0] ctrl_prev;
  logic commit_prev;

  always #4 clk = ~clk;

  serial_ctrl_shifter dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .status_i(status), .sdo_o(sdo), .sdo_en_o(sdo_en), .ctrl_o(ctrl), .commit_o(commit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ev);
    n_cmp++;
    if (act !== ev) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, ev, $time);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison: strobe width and ctrl changing only with a strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (commit) commits_seen++;
      chk("R7 strobe width", {31'd0, commit && commit_prev}, 32'd0);
      chk("R7 R8 ctrl moves only with strobe", {31'd0, (ctrl !== ctrl_prev) && !commit}, 32'd0);
    end
    ctrl_prev   = ctrl;
    commit_prev = commit;
  end

  task automatic frame(input int nbits, input logic [63:0] bits,
                       input logic [15:0] st, input bit perturb);
    logic ev;
    string tag;
    status = st;
    cs_n = 1'b0;
    wcyc(8);
    chk("R2 enable in frame", {31'd0, sdo_en}, 32'd1);
    chk("R3 first status bit", {31'd0, sdo}, {31'd0, st[0]});
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[i];
      wcyc(4);
      if (perturb && i == 2) status = ~st;
      sck = 1'b0;
      wcyc(8);
      sck = 1'b1;
      wcyc(8);
      if (i + 1 < 16) begin
        ev  = st[i+1];
        tag = perturb ? "R10 status frozen" : "R5 status bit";
      end else begin
        ev  = bits[i+1-16];
        tag = "R6 forwarded bit";
      end
      chk(tag, {31'd0, sdo}, {31'd0, ev});
    end
    cs_n = 1'b1;
    wcyc(8);
    chk("R2 enable after frame", {31'd0, sdo_en}, 32'd0);
    if (nbits > 0 && nbits % 16 == 0) begin
      ctrl_exp = bits[nbits-16 +: 16];
      commits_exp++;
      chk("R4 R7 committed word", {16'd0, ctrl}, {16'd0, ctrl_exp});
    end else begin
      chk("R8 word kept", {16'd0, ctrl}, {16'd0, ctrl_exp});
    end
    chk("R7 R8 strobe count", commits_seen, commits_exp);
    wcyc(4);
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wcyc(3);
    chk("R1 reset ctrl", {16'd0, ctrl}, 32'h2000);
    chk("R1 reset strobe", {31'd0, commit}, 32'd0);
    chk("R1 reset enable", {31'd0, sdo_en}, 32'd0);
    rst_n = 1'b1;
    wcyc(4);

    frame(0, 64'h0, 16'h0001, 1'b0);                  // warning poll without clocks
    frame(16, 64'h0000_0000_0000_A5C3, 16'h5A5A, 1'b0);
    frame(10, 64'h0000_0000_0000_03FF, 16'hC3A5, 1'b0); // early end
    frame(17, 64'h0000_0000_0001_FFFF, 16'h1248, 1'b0); // one past a word
    frame(32, 64'h0000_0000_8001_1234, 16'hF00F, 1'b0); // chained
    frame(16, 64'h0000_0000_0000_0FF0, 16'h3C3C, 1'b1);

    // R9: clocks with select high
    sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sck = 1'b0; wcyc(6);
      sck = 1'b1; wcyc(6);
    end
    wcyc(6);
    chk("R9 word kept", {16'd0, ctrl}, {16'd0, ctrl_exp});
    chk("R9 no strobe", commits_seen, commits_exp);
    chk("R9 enable low", {31'd0, sdo_en}, 32'd0);

    frame(16, 64'h0000_0000_0000_8000, 16'hFFFE, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule